// File: doc/BRIEF.md
# DDR SDRAM Power-Up Command Sequencer

This block walks freshly powered DDR SDRAM through its initialisation commands, one physical rank at a time. A single `start` pulse captures the rank count, the CAS latency selection and the rank boundary. The block then waits out the power-up settling time and issues, for every rank, a no-operation, a precharge of all banks, two setup mode-register writes, a second precharge, a series of auto-refreshes and a final mode-register write. It ends each rank with an entry into normal operation.

Each command appears for exactly one cycle on a small command port: a 3-bit code, a full address and a valid strobe. Spacing between commands comes from one shared down-counter, and parameters set its reload values in clock cycles. Whatever consumes the port (a PHY, an arbiter) turns the pulses into pin activity. The address of every command is the current rank's base plus a command-specific offset. Rank 0 starts at zero. The next rank starts at the boundary value times 16 MB.

FSM states: `ST_IDLE` (waits for start), `ST_GAP` (counts the spacing and then moves to the stored resume state), `ST_NOP`, `ST_PRE_A`, `ST_EMRS`, `ST_DLLRST`, `ST_PRE_B`, `ST_REFRESH`, `ST_MODESET`, `ST_NORMAL` and `ST_DONE`. Transitions:
- idle→gap on start.
- gap→resume state when the counter expires.
- Every command state→gap, except one case: normal on the last rank→done.
- refresh→gap with resume refresh, until the last refresh, which resumes to modeset.
- normal→gap with resume nop for the next rank.
- done→idle.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is held, and afterwards until a start is seen, `cmd_vld` and `done` are 0 and `cmd`/`cmd_addr` are 0.
- R2: The first command (NOP) appears exactly `PWRUP_CYC` cycles after the cycle in which `start` is sampled high in idle.
- R3: Command codes are 000 normal entry, 001 NOP, 010 precharge-all, 011 mode-register set and 100 auto-refresh. Each rank receives, in this order: NOP, precharge-all, mode set at offset 0x2000, mode set at offset 0x800, precharge-all, `NUM_REF` (8) refreshes, the final mode set, then normal entry.
- R4: Issue-to-issue spacing is `MRD_CYC` after each of the two setup mode sets and `RFC_CYC` after every refresh, including the last. Every other spacing is `CMD_CYC`, including normal entry to the next rank's NOP.
- R5: The final mode-set offset is a 10-bit word: CAS code in [9:7], burst type in [6], burst length code in [5:3] and zeros in [2:0]. With the default burst settings (type 1, length code 010), `cas_sel` 0 (CL2) gives 0x150, 1 (CL2.5) gives 0x350, 2 (CL3) gives 0x1D0 and 3 (CL1.5) gives 0x2D0.
- R6: Every address is the rank base plus the offset. NOP, precharge, refresh and normal entry use offset 0. Rank 0's base is 0, and rank 1's base is `rank_bound` << 24.
- R7: A `rank_cnt` of 0 runs one rank. Values above `MAX_RANKS` (2) run `MAX_RANKS` ranks.
- R8: `cmd_vld` is high for one cycle per command and never in two consecutive cycles. When it is low, `cmd` and `cmd_addr` are 0.
- R9: `done` is high for exactly one cycle, the cycle after the last rank's normal entry. No command follows until the next start.
- R10: `start` pulses while a sequence runs are ignored. Changes to `rank_cnt`, `cas_sel` and `rank_bound` after the start is accepted do not affect the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a power-up sequence (accepted only when idle) |
| rank_cnt | input | 2 | Number of ranks to initialise (0 means 1) |
| cas_sel | input | 2 | CAS latency choice: 0 CL2, 1 CL2.5, 2 CL3, 3 CL1.5 |
| rank_bound | input | 8 | End of rank 0 in 16 MB units, base of rank 1 |
| cmd | output | 3 | Command code |
| cmd_addr | output | 32 | Command address |
| cmd_vld | output | 1 | One-cycle command strobe |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that every spacing parameter is at least two cycles, which keeps strobes apart. They also assume that `NUM_REF` refreshes sit between the two precharges and the final mode set. The bench keeps its overridden spacings at 3, 5 and 9 cycles and the power-up wait at 20. It draws rank counts, CAS choices and boundaries over their full input ranges, including 0 and 3 for the rank count. Start pulses and input changes in mid-sequence are injected only in a directed case, where the expected stream is the one latched at the accepted start.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    typedef enum logic [2:0] {
        CMD_NORMAL  = 3'b000,
        CMD_NOP     = 3'b001,
        CMD_PREALL  = 3'b010,
        CMD_MRS     = 3'b011,
        CMD_REFRESH = 3'b100
    } ddr_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_GAP,
        ST_NOP,
        ST_PRE_A,
        ST_EMRS,
        ST_DLLRST,
        ST_PRE_B,
        ST_REFRESH,
        ST_MODESET,
        ST_NORMAL,
        ST_DONE
    } seq_state_e;

    // offsets of the two setup mode-register writes
    localparam logic [31:0] OFS_EXT_MODE  = 32'h0000_2000;
    localparam logic [31:0] OFS_DLL_RESET = 32'h0000_0800;

    localparam int MRS_OFS_W = 10;

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign expire = (cnt == CNT_W'(1));

endmodule

// File: rtl/ddr_init_modeaddr.sv
module ddr_init_modeaddr
    import ddr_init_pkg::*;
#(
    parameter logic       BURST_TYPE = 1'b1,
    parameter logic [2:0] BL_CODE    = 3'b010
) (
    input  logic [1:0]           cas_sel,
    output logic [MRS_OFS_W-1:0] mrs_ofs
);
    logic [2:0] cl_code;

    always_comb begin
        unique case (cas_sel)
            2'd0: cl_code = 3'b010;   // CL2
            2'd1: cl_code = 3'b110;   // CL2.5
            2'd2: cl_code = 3'b011;   // CL3
            2'd3: cl_code = 3'b101;   // CL1.5
            default: cl_code = 3'b010;
        endcase
    end

    // low three bits select a byte in the 64-bit word
    assign mrs_ofs = {cl_code, BURST_TYPE, BL_CODE, 3'b000};

endmodule

// File: rtl/ddr_init_rankbase.sv
module ddr_init_rankbase #(
    parameter int RANKS  = 2,
    parameter int END_W  = 8,
    parameter int ADDR_W = 32,
    parameter int SHIFT  = 24,
    localparam int BND_N = (RANKS > 1) ? RANKS - 1 : 1
) (
    input  logic [BND_N*END_W-1:0] bound,
    output logic [ADDR_W-1:0]      base [RANKS]
);
    for (genvar k = 0; k < RANKS; k++) begin : g_rank
        if (k == 0) begin : g_first
            assign base[k] = '0;
        end else begin : g_next
            assign base[k] = ADDR_W'(bound[(k-1)*END_W +: END_W]) << SHIFT;
        end
    end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int         MAX_RANKS  = 2,
    parameter int         END_W      = 8,
    parameter int         ADDR_W     = 32,
    parameter int         BASE_SHIFT = 24,
    parameter int         PWRUP_CYC  = 25000,
    parameter int         MRD_CYC    = 125,
    parameter int         RFC_CYC    = 12500,
    parameter int         CMD_CYC    = 4,
    parameter int         NUM_REF    = 8,
    parameter logic       BURST_TYPE = 1'b1,
    parameter logic [2:0] BL_CODE    = 3'b010
) (
    input  logic                                                 clk,
    input  logic                                                 rst_n,
    input  logic                                                 start,
    input  logic [$clog2(MAX_RANKS+1)-1:0]                       rank_cnt,
    input  logic [1:0]                                           cas_sel,
    input  logic [((MAX_RANKS > 1) ? MAX_RANKS-1 : 1)*END_W-1:0] rank_bound,
    output logic [2:0]                                           cmd,
    output logic [ADDR_W-1:0]                                    cmd_addr,
    output logic                                                 cmd_vld,
    output logic                                                 done
);
    localparam int RC_W   = $clog2(MAX_RANKS + 1);
    localparam int RI_W   = (MAX_RANKS > 1) ? $clog2(MAX_RANKS) : 1;
    localparam int BND_W  = ((MAX_RANKS > 1) ? MAX_RANKS - 1 : 1) * END_W;
    localparam int G_PWR  = (PWRUP_CYC < 2) ? 2 : PWRUP_CYC;
    localparam int G_MRD  = (MRD_CYC   < 2) ? 2 : MRD_CYC;
    localparam int G_RFC  = (RFC_CYC   < 2) ? 2 : RFC_CYC;
    localparam int G_CMD  = (CMD_CYC   < 2) ? 2 : CMD_CYC;
    localparam int G_MAX1 = (G_PWR > G_RFC) ? G_PWR : G_RFC;
    localparam int G_MAX2 = (G_MRD > G_CMD) ? G_MRD : G_CMD;
    localparam int G_MAX  = (G_MAX1 > G_MAX2) ? G_MAX1 : G_MAX2;
    localparam int TW     = $clog2(G_MAX + 1);
    localparam int RFW    = $clog2(NUM_REF + 1);

    seq_state_e              state, resume;
    logic [RI_W-1:0]         rank_idx;
    logic [RFW-1:0]          ref_cnt;
    logic [RC_W-1:0]         ranks_l;
    logic [1:0]              cas_l;
    logic [BND_W-1:0]        bound_l;

    logic                    tmr_load;
    logic [TW-1:0]           tmr_val;
    logic                    tmr_expire;
    logic [MRS_OFS_W-1:0]    mrs_ofs;
    logic [ADDR_W-1:0]       base_arr [MAX_RANKS];
    logic [ADDR_W-1:0]       base;
    logic                    last_rank;
    logic                    last_ref;

    function automatic logic [RC_W-1:0] clamp_ranks(input logic [RC_W-1:0] n);
        if (n == '0) begin
            return RC_W'(1);
        end else if (int'(n) > MAX_RANKS) begin
            return RC_W'(MAX_RANKS);
        end else begin
            return n;
        end
    endfunction

    ddr_init_timer #(.CNT_W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_expire)
    );

    ddr_init_modeaddr #(.BURST_TYPE(BURST_TYPE), .BL_CODE(BL_CODE)) u_modeaddr (
        .cas_sel (cas_l),
        .mrs_ofs (mrs_ofs)
    );

    ddr_init_rankbase #(
        .RANKS  (MAX_RANKS),
        .END_W  (END_W),
        .ADDR_W (ADDR_W),
        .SHIFT  (BASE_SHIFT)
    ) u_rankbase (
        .bound (bound_l),
        .base  (base_arr)
    );

    assign base      = base_arr[rank_idx];
    assign last_rank = (RC_W'(rank_idx) == (ranks_l - RC_W'(1)));
    assign last_ref  = (ref_cnt == RFW'(NUM_REF - 1));

    // state register and sequencing bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            resume   <= ST_IDLE;
            rank_idx <= '0;
            ref_cnt  <= '0;
            ranks_l  <= RC_W'(1);
            cas_l    <= '0;
            bound_l  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        ranks_l  <= clamp_ranks(rank_cnt);
                        cas_l    <= cas_sel;
                        bound_l  <= rank_bound;
                        rank_idx <= '0;
                        ref_cnt  <= '0;
                        resume   <= ST_NOP;
                        state    <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (tmr_expire) begin
                        state <= resume;
                    end
                end
                ST_NOP: begin
                    resume <= ST_PRE_A;
                    state  <= ST_GAP;
                end
                ST_PRE_A: begin
                    resume <= ST_EMRS;
                    state  <= ST_GAP;
                end
                ST_EMRS: begin
                    resume <= ST_DLLRST;
                    state  <= ST_GAP;
                end
                ST_DLLRST: begin
                    resume <= ST_PRE_B;
                    state  <= ST_GAP;
                end
                ST_PRE_B: begin
                    ref_cnt <= '0;
                    resume  <= ST_REFRESH;
                    state   <= ST_GAP;
                end
                ST_REFRESH: begin
                    ref_cnt <= ref_cnt + RFW'(1);
                    resume  <= last_ref ? ST_MODESET : ST_REFRESH;
                    state   <= ST_GAP;
                end
                ST_MODESET: begin
                    resume <= ST_NORMAL;
                    state  <= ST_GAP;
                end
                ST_NORMAL: begin
                    if (last_rank) begin
                        state <= ST_DONE;
                    end else begin
                        rank_idx <= rank_idx + RI_W'(1);
                        resume   <= ST_NOP;
                        state    <= ST_GAP;
                    end
                end
                ST_DONE: begin
                    state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // outputs and spacing reload
    always_comb begin
        cmd      = CMD_NORMAL;
        cmd_addr = '0;
        cmd_vld  = 1'b0;
        done     = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    tmr_load = 1'b1;
                    tmr_val  = TW'(G_PWR - 1);
                end
            end
            ST_GAP: begin
            end
            ST_NOP: begin
                cmd_vld  = 1'b1;
                cmd      = CMD_NOP;
                cmd_addr = base;
                tmr_load = 1'b1;
                tmr_val  = TW'(G_CMD - 1);
            end
            ST_PRE_A, ST_PRE_B: begin
                cmd_vld  = 1'b1;
                cmd      = CMD_PREALL;
                cmd_addr = base;
                tmr_load = 1'b1;
                tmr_val  = TW'(G_CMD - 1);
            end
            ST_EMRS: begin
                cmd_vld  = 1'b1;
                cmd      = CMD_MRS;
                cmd_addr = base + ADDR_W'(OFS_EXT_MODE);
                tmr_load = 1'b1;
                tmr_val  = TW'(G_MRD - 1);
            end
            ST_DLLRST: begin
                cmd_vld  = 1'b1;
                cmd      = CMD_MRS;
                cmd_addr = base + ADDR_W'(OFS_DLL_RESET);
                tmr_load = 1'b1;
                tmr_val  = TW'(G_MRD - 1);
            end
            ST_REFRESH: begin
                cmd_vld  = 1'b1;
                cmd      = CMD_REFRESH;
                cmd_addr = base;
                tmr_load = 1'b1;
                tmr_val  = TW'(G_RFC - 1);
            end
            ST_MODESET: begin
                cmd_vld  = 1'b1;
                cmd      = CMD_MRS;
                cmd_addr = base + ADDR_W'(mrs_ofs);
                tmr_load = 1'b1;
                tmr_val  = TW'(G_CMD - 1);
            end
            ST_NORMAL: begin
                cmd_vld  = 1'b1;
                cmd      = CMD_NORMAL;
                cmd_addr = base;
                if (!last_rank) begin
                    tmr_load = 1'b1;
                    tmr_val  = TW'(G_CMD - 1);
                end
            end
            ST_DONE: begin
                done = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
    parameter int ADDR_W  = 32,
    parameter int NUM_REF = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        cmd,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              cmd_vld,
    input logic              done
);
    localparam int RFW = $clog2(NUM_REF + 1);

    logic [2:0]     last_cmd;
    logic [RFW-1:0] refs;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_cmd <= 3'b000;
            refs     <= '0;
        end else if (cmd_vld) begin
            last_cmd <= cmd;
            if (cmd == 3'b001) begin
                refs <= '0;
            end else if (cmd == 3'b100) begin
                refs <= refs + RFW'(1);
            end
        end
    end

    // R8
    vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld |=> !cmd_vld);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_vld |-> (cmd == 3'b000 && cmd_addr == '0));

    // R3
    code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld |-> (cmd <= 3'b100));

    // R3
    nop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && last_cmd == 3'b000) |-> (cmd == 3'b001));

    // R3
    pre_after_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && last_cmd == 3'b001) |-> (cmd == 3'b010));

    // R3
    ref_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd == 3'b100) |-> (refs < RFW'(NUM_REF)));

    // R3
    mrs_refs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd == 3'b011) |-> (refs == '0 || refs == RFW'(NUM_REF)));

    // R9
    done_after_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (last_cmd == 3'b000 && !cmd_vld));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !cmd_vld));

endmodule

bind ddr_init_seq ddr_init_seq_chk #(.ADDR_W(ADDR_W), .NUM_REF(NUM_REF)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .cmd_addr (cmd_addr),
    .cmd_vld  (cmd_vld),
    .done     (done)
);

// File: tb/ddr_init_seq_tb.sv
module ddr_init_seq_tb;

    localparam int P  = 20;
    localparam int C  = 3;
    localparam int M  = 5;
    localparam int R  = 9;
    localparam int NR = 8;
    localparam int MAXQ = 64;
    localparam int WD_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  rank_cnt = 2'd0;
    logic [1:0]  cas_sel = 2'd0;
    logic [7:0]  rank_bound = 8'd0;
    logic [2:0]  cmd;
    logic [31:0] cmd_addr;
    logic        cmd_vld;
    logic        done;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    logic [2:0]  got_cmd  [MAXQ];
    logic [31:0] got_addr [MAXQ];
    int          got_t    [MAXQ];
    int          n_got = 0;
    int          done_n = 0;
    int          done_t = 0;

    logic [2:0]  exp_cmd  [MAXQ];
    logic [31:0] exp_addr [MAXQ];
    int          exp_t    [MAXQ];
    bit          exp_fin  [MAXQ];
    int          n_exp = 0;
    int          exp_done = 0;

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    ddr_init_seq #(
        .PWRUP_CYC (P),
        .CMD_CYC   (C),
        .MRD_CYC   (M),
        .RFC_CYC   (R),
        .NUM_REF   (NR)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .rank_cnt   (rank_cnt),
        .cas_sel    (cas_sel),
        .rank_bound (rank_bound),
        .cmd        (cmd),
        .cmd_addr   (cmd_addr),
        .cmd_vld    (cmd_vld),
        .done       (done)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_vld) begin
                if (n_got < MAXQ) begin
                    got_cmd[n_got]  = cmd;
                    got_addr[n_got] = cmd_addr;
                    got_t[n_got]    = cyc;
                end
                n_got = n_got + 1;
            end
            if (done) begin
                done_t = cyc;
                done_n = done_n + 1;
            end
        end
    end

    always @(posedge clk) begin
        if (cyc == WD_LIMIT) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog run did not end got=%0d exp=%0d", cyc, WD_LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        checks = checks + 1;
        if (got !== exp) begin
            errors = errors + 1;
            $display("FAIL %s %s got=%0h exp=%0h", req, what, got, exp);
        end
    endtask

    function automatic int exp_ranks(input logic [1:0] rc);   // R7
        if (rc == 2'd0) return 1;
        if (rc > 2'd2) return 2;
        return int'(rc);
    endfunction

    function automatic logic [31:0] exp_mrs(input logic [1:0] cs);   // R5
        case (cs)
            2'd0: return 32'h150;
            2'd1: return 32'h350;
            2'd2: return 32'h1D0;
            default: return 32'h2D0;
        endcase
    endfunction

    task automatic push(input logic [2:0] c, input logic [31:0] a, input int t, input bit fin);
        exp_cmd[n_exp]  = c;
        exp_addr[n_exp] = a;
        exp_t[n_exp]    = t;
        exp_fin[n_exp]  = fin;
        n_exp = n_exp + 1;
    endtask

    task automatic build_exp(input logic [1:0] rc, input logic [1:0] cs, input logic [7:0] bnd, input int t0);
        int t;
        logic [31:0] b;
        n_exp = 0;
        t = t0 + P;
        for (int r = 0; r < exp_ranks(rc); r++) begin
            b = (r == 0) ? 32'h0 : ({24'h0, bnd} << 24);   // R6
            push(3'b001, b, t, 1'b0);            t = t + C;
            push(3'b010, b, t, 1'b0);            t = t + C;
            push(3'b011, b + 32'h2000, t, 1'b0); t = t + M;
            push(3'b011, b + 32'h800, t, 1'b0);  t = t + M;
            push(3'b010, b, t, 1'b0);            t = t + C;
            for (int i = 0; i < NR; i++) begin
                push(3'b100, b, t, 1'b0);        t = t + R;
            end
            push(3'b011, b + exp_mrs(cs), t, 1'b1); t = t + C;
            push(3'b000, b, t, 1'b0);
            exp_done = t + 1;
            t = t + C;
        end
    endtask

    task automatic run_case(input logic [1:0] rc, input logic [1:0] cs, input logic [7:0] bnd, input bit disturb);
        int wait_n;
        int lim;
        @(negedge clk);
        n_got = 0;
        done_n = 0;
        rank_cnt = rc;
        cas_sel = cs;
        rank_bound = bnd;
        start = 1'b1;
        build_exp(rc, cs, bnd, cyc);
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            // R10: start and input changes mid-run must not matter
            repeat (30) @(negedge clk);
            start = 1'b1;
            cas_sel = ~cs;
            rank_bound = ~bnd;
            rank_cnt = ~rc;
            @(negedge clk);
            start = 1'b0;
            repeat (60) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_n = 0;
        while (done_n == 0 && wait_n < 4000) begin
            @(negedge clk);
            wait_n = wait_n + 1;
        end
        @(negedge clk);
        chk("R9", "done seen", 64'(done_n != 0), 64'd1);
        chk("R7", "command count", 64'(n_got), 64'(n_exp));
        lim = (n_got < n_exp) ? n_got : n_exp;
        if (lim > MAXQ) lim = MAXQ;
        for (int i = 0; i < lim; i++) begin
            chk("R3", "command code", 64'(got_cmd[i]), 64'(exp_cmd[i]));
            if (exp_fin[i])
                chk("R5", "final mode address", 64'(got_addr[i]), 64'(exp_addr[i]));
            else
                chk("R6", "command address", 64'(got_addr[i]), 64'(exp_addr[i]));
            if (i == 0)
                chk("R2", "power-up wait", 64'(got_t[i]), 64'(exp_t[i]));
            else
                chk("R4", "command spacing", 64'(got_t[i]), 64'(exp_t[i]));
        end
        chk("R9", "done cycle", 64'(done_t), 64'(exp_done));
        repeat (8) @(negedge clk);
        chk("R9", "no command after done", 64'(n_got), 64'(n_exp));
        chk("R9", "single done pulse", 64'(done_n), 64'd1);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            chk("R1", "vld in reset", 64'(cmd_vld), 64'd0);
            chk("R1", "done in reset", 64'(done), 64'd0);
            chk("R1", "cmd/addr in reset", {29'd0, cmd, cmd_addr}, 64'd0);
        end
        rst_n = 1'b1;
        repeat (5) begin
            @(negedge clk);
            chk("R1", "idle before start", {27'd0, cmd_vld, done, cmd, cmd_addr}, 64'd0);
        end
        // directed corners
        run_case(2'd0, 2'd0, 8'h10, 1'b0);   // R7 zero ranks -> one, R5 CL2
        run_case(2'd1, 2'd1, 8'h20, 1'b0);   // R5 CL2.5
        run_case(2'd2, 2'd2, 8'h10, 1'b0);   // R6 second rank base, R5 CL3
        run_case(2'd3, 2'd3, 8'hFF, 1'b0);   // R7 clamp, R5 CL1.5, R6 top boundary
        run_case(2'd2, 2'd1, 8'h08, 1'b1);   // R10 disturbance
        // random
        for (int i = 0; i < 10; i++) begin
            run_case(2'($urandom % 4), 2'($urandom % 4), 8'($urandom % 256), 1'b0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule